// File: doc/BRIEF.md
# Disk Controller Data FIFO

This block is the byte buffer between a host bus and a disk-controller core. Sector data and command parameter bytes pass through it in both directions. A direction input chooses which side fills the buffer and which side drains it. In controller-to-host mode the core pushes and the host pops. In host-to-controller mode the host pushes and the core pops. No byte reaches the other side without going through the buffer.

After reset the buffer is disabled and acts as a one-byte holding register. This gives the legacy one-byte-at-a-time handshake. A configure write can enable the full 16-byte depth and load a service threshold. The block then asserts its ready flag and its DMA request early, while a margin equal to the threshold is still left. This gives the host DMA engine time to respond before an overrun or an underrun. A larger threshold gives the host a longer response time after the request.

The block also drives the direction status bit seen by the host. It keeps two sticky error flags for core accesses that the buffer cannot serve.

Top module: `xfer_fifo`

## Requirements
- R1: After a synchronous reset the buffer is disabled and empty, the threshold is 1, `dio` is 0, `rqm` and `dma_req` are 1, and `overrun` and `underrun` are 0.
- R2: When enabled, the buffer holds up to 16 bytes and returns them in write order. A push into a full buffer from the host side is ignored.
- R3: When disabled, the buffer holds one byte. A second push is ignored, and the first byte is the one returned.
- R4: `dio` gives the registered direction: 1 for controller-to-host, 0 for host-to-controller.
- R5: Enabled, controller-to-host: `rqm` is 1 exactly when (16 − stored bytes) ≤ threshold.
- R6: Enabled, host-to-controller: `rqm` is 1 exactly when stored bytes ≤ threshold.
- R7: Disabled: `rqm` is 1 when the single byte is full in controller-to-host mode, or empty in host-to-controller mode.
- R8: A configured threshold of 0 becomes 1, and a value above 15 becomes 15. `dma_req` always equals `rqm`.
- R9: A core push into a full buffer sets the sticky `overrun` flag and drops the byte.
- R10: A core pop from an empty buffer sets the sticky `underrun` flag.
- R11: Both flags clear only on reset or on a configure write. A direction change does not clear them.
- R12: A change of direction, or a configure write that changes the enable, empties the buffer in the same cycle. Any push or pop in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Configure write strobe |
| cfg_en | input | 1 | Enable value for configure write |
| cfg_thr | input | 5 | Raw threshold for configure write |
| dir_to_host | input | 1 | 1: controller-to-host, 0: host-to-controller |
| host_wr | input | 1 | Host push strobe |
| host_wdata | input | 8 | Host push byte |
| host_rd | input | 1 | Host pop strobe |
| host_rdata | output | 8 | Head byte toward host |
| core_wr | input | 1 | Core push strobe |
| core_wdata | input | 8 | Core push byte |
| core_rd | input | 1 | Core pop strobe |
| core_rdata | output | 8 | Head byte toward core |
| rqm | output | 1 | Data port ready for service |
| dio | output | 1 | Transfer direction status |
| dma_req | output | 1 | DMA service request |
| overrun | output | 1 | Sticky core-write-when-full flag |
| underrun | output | 1 | Sticky core-read-when-empty flag |

## Verification
Several properties are checked by assertions on every cycle:
- a flush leaves the buffer empty;
- a push into a full buffer leaves the fill level unchanged;
- the stored threshold always stays between 1 and 15;
- both error flags stay set until a configure write;
- `rqm` never invites a push into a full buffer or a pop from an empty one.

Only the bench scenarios can show the exact threshold crossing point for each threshold and fill level in both directions. The same holds for byte ordering, the one-byte legacy mode, and the effect of a flush seen at the ports.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;

  // Clamp a raw threshold into the legal range 1 .. maxv.
  function automatic int unsigned sat_thr(input int unsigned raw, input int unsigned maxv);
    if (raw == 0) return 1;
    if (raw > maxv) return maxv;
    return raw;
  endfunction

  // Service request rule for both modes and both directions.
  function automatic logic want_service(input logic en, input logic to_host,
                                        input int unsigned fill, input int unsigned thr,
                                        input int unsigned depth);
    if (!en) return to_host ? (fill == 1) : (fill == 0);
    if (to_host) return (depth - fill) <= thr;
    return fill <= thr;
  endfunction

endpackage

// File: rtl/xfer_fifo_store.sv
module xfer_fifo_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full    = (count == (en ? CW'(DEPTH) : CW'(1)));
  assign empty   = (count == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign rdata   = mem[rd_ptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty); // R12
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(count)); // R2
  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (rst)
    !en |-> count <= CW'(1)); // R3

endmodule

// File: rtl/xfer_fifo_ctl.sv
module xfer_fifo_ctl #(
  parameter int DEPTH = 16,
  parameter int RAW_W = 5,
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_en,
  input  logic [RAW_W-1:0] cfg_thr,
  input  logic             dir_in,
  input  logic             ovr_evt,
  input  logic             unr_evt,
  output logic             en,
  output logic [TW-1:0]    thr,
  output logic             dir,
  output logic             flush,
  output logic             overrun,
  output logic             underrun
);
  import xfer_fifo_pkg::*;

  logic dir_chg, en_chg;

  assign dir_chg = (dir_in != dir);
  assign en_chg  = cfg_wr && (cfg_en != en);
  assign flush   = dir_chg || en_chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      thr      <= TW'(1);
      dir      <= 1'b0;
      overrun  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      dir <= dir_in;
      if (cfg_wr) begin
        en       <= cfg_en;
        thr      <= TW'(sat_thr(int'(cfg_thr), DEPTH - 1));
        overrun  <= 1'b0;
        underrun <= 1'b0;
      end else begin
        if (ovr_evt) overrun  <= 1'b1;
        if (unr_evt) underrun <= 1'b1;
      end
    end
  end

  AST_THR_RANGE: assert property (@(posedge clk) disable iff (rst)
    (thr >= TW'(1)) && (int'(thr) <= DEPTH - 1)); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overrun && !cfg_wr) |=> overrun); // R11
  AST_UNR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (underrun && !cfg_wr) |=> underrun); // R11

endmodule

// File: rtl/xfer_fifo_req.sv
module xfer_fifo_req #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          dir,
  input  logic [CW-1:0] count,
  input  logic [TW-1:0] thr,
  input  logic          full,
  input  logic          empty,
  output logic          rqm,
  output logic          dma_req
);
  import xfer_fifo_pkg::*;

  assign rqm     = want_service(en, dir, int'(count), int'(thr), DEPTH);
  assign dma_req = rqm;

  AST_NO_REQ_FULL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!dir && full) |-> !rqm); // R6
  AST_NO_REQ_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (dir && empty) |-> !rqm); // R5

endmodule

// File: rtl/xfer_fifo.sv
module xfer_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int RAW_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_en,
  input  logic [RAW_W-1:0] cfg_thr,
  input  logic             dir_to_host,
  input  logic             host_wr,
  input  logic [DW-1:0]    host_wdata,
  input  logic             host_rd,
  output logic [DW-1:0]    host_rdata,
  input  logic             core_wr,
  input  logic [DW-1:0]    core_wdata,
  input  logic             core_rd,
  output logic [DW-1:0]    core_rdata,
  output logic             rqm,
  output logic             dio,
  output logic             dma_req,
  output logic             overrun,
  output logic             underrun
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(DEPTH);

  logic          en, dir, flush, full, empty, push, pop, ovr_evt, unr_evt;
  logic [TW-1:0] thr;
  logic [CW-1:0] count;
  logic [DW-1:0] wdata, head;

  // Direction picks which side fills and which side drains.
  assign push    = dir ? core_wr : host_wr;
  assign pop     = dir ? host_rd : core_rd;
  assign wdata   = dir ? core_wdata : host_wdata;
  assign ovr_evt = dir && core_wr && full && !flush;
  assign unr_evt = !dir && core_rd && empty && !flush;

  xfer_fifo_ctl #(.DEPTH(DEPTH), .RAW_W(RAW_W)) ctl_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_thr(cfg_thr),
    .dir_in(dir_to_host), .ovr_evt(ovr_evt), .unr_evt(unr_evt),
    .en(en), .thr(thr), .dir(dir), .flush(flush),
    .overrun(overrun), .underrun(underrun));

  xfer_fifo_store #(.DEPTH(DEPTH), .DW(DW)) store_i (
    .clk(clk), .rst(rst), .en(en), .flush(flush), .push(push), .pop(pop),
    .wdata(wdata), .rdata(head), .count(count), .full(full), .empty(empty));

  xfer_fifo_req #(.DEPTH(DEPTH)) req_i (
    .clk(clk), .rst(rst), .en(en), .dir(dir), .count(count), .thr(thr),
    .full(full), .empty(empty), .rqm(rqm), .dma_req(dma_req));

  assign host_rdata = head;
  assign core_rdata = head;
  assign dio        = dir;

  AST_DIO_TRACKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> dio == $past(dir_to_host)); // R4
  AST_OVR_SETS: assert property (@(posedge clk) disable iff (rst)
    (dio && core_wr && !cfg_wr && dir_to_host && full) |=> overrun); // R9
  AST_UNR_SETS: assert property (@(posedge clk) disable iff (rst)
    (!dio && core_rd && !cfg_wr && !dir_to_host && empty) |=> underrun); // R10

endmodule

// File: tb/xfer_fifo_tb_top.sv
module xfer_fifo_tb_top;
  logic       clk = 0, rst = 1;
  logic       cfg_wr = 0, cfg_en = 0, dir_to_host = 0;
  logic [4:0] cfg_thr = 0;
  logic       host_wr = 0, host_rd = 0, core_wr = 0, core_rd = 0;
  logic [7:0] host_wdata = 0, core_wdata = 0, host_rdata, core_rdata;
  logic       rqm, dio, dma_req, overrun, underrun;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xfer_fifo dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cfg(input bit en, input int t);
    @(negedge clk); cfg_wr = 1; cfg_en = en; cfg_thr = 5'(t);
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic set_dir(input bit d);
    @(negedge clk); dir_to_host = d;
    @(negedge clk);
  endtask

  task automatic hwr(input logic [7:0] b);
    @(negedge clk); host_wr = 1; host_wdata = b;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic cwr(input logic [7:0] b);
    @(negedge clk); core_wr = 1; core_wdata = b;
    @(negedge clk); core_wr = 0;
  endtask

  task automatic hrd();
    @(negedge clk); host_rd = 1;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic crd();
    @(negedge clk); core_rd = 1;
    @(negedge clk); core_rd = 0;
  endtask

  function automatic int exp_thr(input int t);
    int v = t;
    if (v > 15) v = 15;
    if (v < 1)  v = 1;
    return v;
  endfunction

  function automatic logic [7:0] pat(input int t, input int n);
    return 8'((t * 37 + n * 11) ^ 8'h5A);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int tl[10] = '{0, 1, 2, 3, 7, 8, 14, 15, 16, 31};
    repeat (3) @(negedge clk);
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 rqm", rqm, 1); chk("R1 dma_req", dma_req, 1); chk("R1 dio", dio, 0);
    chk("R1 overrun", overrun, 0); chk("R1 underrun", underrun, 0);

    // R3 / R7 disabled legacy mode, host-to-controller
    hwr(8'hA1);
    chk("R7 rqm full h2c", rqm, 0);
    hwr(8'hB2);
    chk("R3 second byte ignored", core_rdata, 8'hA1);
    crd();
    chk("R7 rqm empty h2c", rqm, 1);
    // R4 direction switch, disabled controller-to-host
    set_dir(1);
    chk("R4 dio", dio, 1);
    chk("R7 rqm empty c2h", rqm, 0);
    cwr(8'hC3);
    chk("R7 rqm full c2h", rqm, 1);
    cwr(8'hD4);
    chk("R9 overrun depth1", overrun, 1);
    chk("R3 held byte", host_rdata, 8'hC3);
    hrd();
    chk("R7 rqm after read", rqm, 0);
    set_dir(0);
    chk("R11 overrun survives dir change", overrun, 1);
    chk("R4 dio back", dio, 0);

    // Threshold sweep, both directions
    foreach (tl[k]) begin
      int t = tl[k];
      int e = exp_thr(t);
      cfg(1, t);
      chk("R11 flags cleared by cfg", overrun | underrun, 0);
      // R6 host-to-controller
      for (int n = 0; n <= 16; n++) begin
        chk($sformatf("R6 rqm t=%0d n=%0d", t, n), rqm, int'(n <= e));
        chk("R8 dma_req", dma_req, rqm);
        if (n < 16) hwr(pat(t, n));
      end
      hwr(8'hEE);
      for (int n = 0; n < 16; n++) begin
        chk($sformatf("R2 order h2c t=%0d n=%0d", t, n), core_rdata, pat(t, n));
        crd();
      end
      chk("R2 full push ignored", underrun, 0);
      crd();
      chk("R10 underrun", underrun, 1);
      tick(); tick();
      chk("R11 underrun sticky", underrun, 1);
      // R5 controller-to-host
      set_dir(1);
      for (int n = 0; n <= 16; n++) begin
        chk($sformatf("R5 rqm t=%0d n=%0d", t, n), rqm, int'((16 - n) <= e));
        if (n < 16) cwr(pat(t, n + 1));
      end
      cwr(8'h77);
      chk("R9 overrun", overrun, 1);
      for (int n = 0; n < 16; n++) begin
        chk($sformatf("R2 order c2h t=%0d n=%0d", t, n), host_rdata, pat(t, n + 1));
        hrd();
      end
      chk("R5 rqm empty", rqm, 0);
      set_dir(0);
    end

    // R12 flush on enable change
    cfg(1, 1);
    for (int n = 0; n < 5; n++) hwr(8'(n));
    chk("R12 before flush", rqm, 0);
    cfg(0, 1);
    chk("R12 flushed rqm", rqm, 1);
    crd();
    chk("R12 flushed empty", underrun, 1);
    // R12 flush on direction change
    cfg(1, 2);
    for (int n = 0; n < 6; n++) hwr(8'(n + 40));
    chk("R12 before dir flush", rqm, 0);
    set_dir(1);
    set_dir(0);
    chk("R12 dir flush rqm", rqm, 1);
    crd();
    chk("R12 dir flush empty", underrun, 1);
    // R1 reset restores defaults
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    tick();
    chk("R1 reset clears underrun", underrun, 0);
    hwr(8'h11);
    chk("R1 disabled after reset", rqm, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule